// File: doc/BRIEF.md
# Supply-Qualified Memory Access Guard

This block sits between a memory bus controller and a non-volatile byte-wide memory. It keeps the memory's active-low chip-select and write strobes parked high whenever the supplies cannot be trusted. Three digital status flags come from external comparators: core supply above the start threshold, core supply above its write-inhibit level, and I/O supply above its write-inhibit level. Each flag is synchronized to the local clock and debounced before the guard acts on it.

After reset, the guard waits until all three flags are good. It then counts a startup interval, given in microseconds and converted to clock cycles from a clock-frequency parameter, before it raises `ready_o`. While ready, the controller's strobes pass straight through. If either inhibit-level flag drops, the guard leaves the ready state, pulses an abort to the controller, and records a sticky brownout flag. Getting back to ready needs the start-threshold flag again and a complete new startup interval. Once ready, losing only the start-threshold flag (a core supply sagging into its lower operating band) changes nothing.

Top module: `pwr_access_guard`

## Requirements
- R1: While `rst_n` is low, with no clock edge needed, `ready_o`=0, `mem_ce_n_o`=1, `mem_we_n_o`=1, `abort_o`=0 and `brownout_seen_o`=0.
- R2: `ready_o` stays 0 while `core_start_i` is 0, even when both inhibit-level flags are 1.
- R3: With S=2 synchronizer stages, F=`FILT_CYCLES` and N=`CLK_HZ`*`STARTUP_US`/1000000, `ready_o` rises exactly S+F+1+N clock edges after the last of the three flags goes to 1. The flag change is made between edge 0 and edge 1.
- R4: While `ready_o`=1, `mem_ce_n_o` equals `req_ce_n_i` and `mem_we_n_o` equals `req_we_n_i`, for all four combinations.
- R5: While `ready_o`=0, both strobe outputs are 1 whatever the request inputs are.
- R6: Once `ready_o`=1, dropping `core_start_i` alone leaves `ready_o` at 1.
- R7: When `core_ok_i` or `io_ok_i` goes to 0 while ready, `ready_o` falls exactly S+F+1 edges later.
- R8: A flag pulse that lasts F-1 clock cycles or fewer is ignored.
- R9: On entry to the inhibit state, `abort_o` is 1 for exactly one cycle, in the same cycle that `ready_o` falls.
- R10: `brownout_seen_o` is set on entry to the inhibit state and stays 1 until `clr_brownout_i` is sampled high at a clock edge.
- R11: After an inhibit, good inhibit-level flags alone do not restore `ready_o`. A rise of `core_start_i` restores it after the full R3 delay.
- R12: If `core_start_i` is lost during the startup count, the count is discarded, and a later rise again takes the full R3 delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside |
| core_start_i | input | 1 | Core supply above start threshold (asynchronous) |
| core_ok_i | input | 1 | Core supply above write-inhibit level (asynchronous) |
| io_ok_i | input | 1 | I/O supply above write-inhibit level (asynchronous) |
| req_ce_n_i | input | 1 | Controller chip-select request, active low |
| req_we_n_i | input | 1 | Controller write-strobe request, active low |
| clr_brownout_i | input | 1 | Clears the sticky brownout flag |
| mem_ce_n_o | output | 1 | Guarded chip select to memory, active low |
| mem_we_n_o | output | 1 | Guarded write strobe to memory, active low |
| ready_o | output | 1 | Memory may be accessed |
| abort_o | output | 1 | One-cycle pulse telling the controller to drop its access |
| brownout_seen_o | output | 1 | Sticky: an inhibit has occurred |

## Verification
The bench counts the exact edge on which ready rises and falls. An off-by-one in the debounce or the startup counter shows up as a count one edge too short or too long. It drops the start flag partway through a startup count and then restores it. A counter that is not cleared would raise ready early. It drops the start flag while ready, which a guard without separate entry and exit conditions would wrongly treat as an inhibit. It applies a pulse one cycle shorter than the debounce window, which an unfiltered design would turn into a spurious abort. It also holds the strobe requests active across the inhibit, so any leak of a request past the guard is seen at the memory pins.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

  typedef enum logic [2:0] {
    GS_RESET   = 3'd0,
    GS_WAIT    = 3'd1,
    GS_STARTUP = 3'd2,
    GS_READY   = 3'd3,
    GS_INHIBIT = 3'd4
  } guard_state_t;

  // flag index inside the filtered vector
  localparam int FLAG_START = 0;
  localparam int FLAG_CORE  = 1;
  localparam int FLAG_IO    = 2;
  localparam int NUM_FLAGS  = 3;

  // cycles in the startup window; never less than one
  function automatic int startup_cycles(input longint clk_hz, input longint window_us);
    longint c;
    c = (clk_hz * window_us) / 64'd1000000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/pg_flag_filter.sv
module pg_flag_filter #(
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int FW = $clog2(FILT_CYCLES + 1);

  logic [1:0]    sync_pipe;
  logic          sync_q;
  logic [FW-1:0] run_cnt;
  logic          differs;
  logic          commit;

  assign sync_q  = sync_pipe[1];
  assign differs = (sync_q != filt_o);
  assign commit  = differs && (run_cnt == FW'(FILT_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_pipe <= '0;
      run_cnt   <= '0;
      filt_o    <= 1'b0;
    end else begin
      sync_pipe <= {sync_pipe[0], raw_i};
      if (commit) begin
        filt_o  <= sync_q;
        run_cnt <= '0;
      end else if (differs) begin
        run_cnt <= run_cnt + 1'b1;
      end else begin
        run_cnt <= '0;
      end
    end
  end

  // R8
  filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_o != $past(filt_o)) |-> ($past(sync_q) == filt_o));

endmodule

// File: rtl/pg_startup_timer.sv
module pg_startup_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  assign done_o = run_i && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear_i)          cnt <= '0;
    else if (run_i && !done_o) cnt <= cnt + 1'b1;
  end

  // R12
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == '0 || cnt == CW'($past(cnt) + 1'b1)));

endmodule

// File: rtl/pwr_access_guard.sv
module pwr_access_guard
  import pwr_guard_pkg::*;
#(
  parameter longint CLK_HZ      = 250_000_000,
  parameter longint STARTUP_US  = 2000,
  parameter int     FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic core_start_i,
  input  logic core_ok_i,
  input  logic io_ok_i,
  input  logic req_ce_n_i,
  input  logic req_we_n_i,
  input  logic clr_brownout_i,
  output logic mem_ce_n_o,
  output logic mem_we_n_o,
  output logic ready_o,
  output logic abort_o,
  output logic brownout_seen_o
);
  localparam int START_N = startup_cycles(CLK_HZ, STARTUP_US);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // flag conditioning
  logic [NUM_FLAGS-1:0] raw_flags;
  logic [NUM_FLAGS-1:0] flt;
  assign raw_flags[FLAG_START] = core_start_i;
  assign raw_flags[FLAG_CORE]  = core_ok_i;
  assign raw_flags[FLAG_IO]    = io_ok_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_filt
    pg_flag_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .raw_i  (raw_flags[g]),
      .filt_o (flt[g])
    );
  end

  // named events
  logic inhibit_hit;
  logic start_cond;
  logic tmr_done;
  assign inhibit_hit = !(flt[FLAG_CORE] && flt[FLAG_IO]);
  assign start_cond  = &flt;

  guard_state_t state_q, state_d;

  pg_startup_timer #(.CYCLES(START_N)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear_i (state_q != GS_STARTUP),
    .run_i   (state_q == GS_STARTUP),
    .done_o  (tmr_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GS_RESET:   state_d = GS_WAIT;
      GS_WAIT:    if (start_cond) state_d = GS_STARTUP;
      GS_STARTUP: begin
        if (inhibit_hit)             state_d = GS_INHIBIT;
        else if (!flt[FLAG_START])   state_d = GS_WAIT;
        else if (tmr_done)           state_d = GS_READY;
      end
      GS_READY:   if (inhibit_hit) state_d = GS_INHIBIT;
      GS_INHIBIT: if (start_cond)  state_d = GS_STARTUP;
      default:    state_d = GS_RESET;
    endcase
  end

  logic enter_inhibit;
  assign enter_inhibit = (state_d == GS_INHIBIT) && (state_q != GS_INHIBIT);

  logic abort_q, seen_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= GS_RESET;
      abort_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= enter_inhibit;
      seen_q  <= enter_inhibit || (seen_q && !clr_brownout_i);
    end
  end

  assign ready_o         = (state_q == GS_READY);
  assign abort_o         = abort_q;
  assign brownout_seen_o = seen_q;
  assign mem_ce_n_o      = ready_o ? req_ce_n_i : 1'b1;
  assign mem_we_n_o      = ready_o ? req_we_n_i : 1'b1;

  // R7
  inhibit_entry_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ready_o && inhibit_hit) |=> (!ready_o && abort_o));

  // R9
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    abort_o |=> !abort_o);

  // R3
  ready_entry_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ready_o) |-> $past(tmr_done && start_cond));

  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ready_o && !inhibit_hit) |=> ready_o);

  // R10
  seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (brownout_seen_o && !clr_brownout_i) |=> brownout_seen_o);

endmodule

// File: tb/pwr_access_guard_tb.sv
module pwr_access_guard_tb;
  localparam longint CLK_HZ = 1_000_000;
  localparam longint WIN_US = 20;
  localparam int     FILT   = 3;
  localparam int     N      = int'((CLK_HZ * WIN_US) / 1000000);
  localparam int     RISE_LAT = 2 + FILT + 1 + N;
  localparam int     FALL_LAT = 2 + FILT + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_start = 1'b0, core_ok = 1'b0, io_ok = 1'b0;
  logic req_ce_n = 1'b0, req_we_n = 1'b0, clr_bo = 1'b0;
  logic mem_ce_n, mem_we_n, ready, abort_p, bo_seen;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwr_access_guard #(.CLK_HZ(CLK_HZ), .STARTUP_US(WIN_US), .FILT_CYCLES(FILT)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_start_i(core_start), .core_ok_i(core_ok),
    .io_ok_i(io_ok), .req_ce_n_i(req_ce_n), .req_we_n_i(req_we_n),
    .clr_brownout_i(clr_bo), .mem_ce_n_o(mem_ce_n), .mem_we_n_o(mem_we_n),
    .ready_o(ready), .abort_o(abort_p), .brownout_seen_o(bo_seen)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // counts edges until ready reaches lvl, sampling 1 ns after each edge
  task automatic edges_until(input logic lvl, input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      @(posedge clk); #1;
      n++;
      if (ready == lvl) break;
    end
  endtask

  task automatic hold_not_ready(input string req, input int cyc);
    int bad = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (ready !== 1'b0) bad++;
    end
    check(req, bad, 0);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    int n;
    // R1: reset state with requests active
    repeat (3) @(negedge clk);
    check("R1 ready", ready, 0);
    check("R1 ce", mem_ce_n, 1);
    check("R1 we", mem_we_n, 1);
    check("R1 abort", abort_p, 0);
    check("R1 seen", bo_seen, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R2: inhibit-level flags good, start flag low
    core_ok = 1'b1; io_ok = 1'b1;
    hold_not_ready("R2 no start flag", 40);
    check("R5 ce idle", mem_ce_n, 1);
    check("R5 we idle", mem_we_n, 1);

    // R3: startup latency
    core_start = 1'b1;
    edges_until(1'b1, 200, n);
    check("R3 rise latency", n, RISE_LAT);

    // R4: pass-through sweep
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      req_ce_n = v[0]; req_we_n = v[1];
      #1;
      check("R4 ce pass", mem_ce_n, v[0]);
      check("R4 we pass", mem_we_n, v[1]);
    end
    @(negedge clk); req_ce_n = 1'b0; req_we_n = 1'b0;

    // R6: start flag lost alone while ready
    core_start = 1'b0;
    repeat (40) @(negedge clk);
    check("R6 ready kept", ready, 1);
    check("R6 no brownout", bo_seen, 0);

    // R8: short glitch on core inhibit flag
    core_ok = 1'b0;
    repeat (FILT - 1) @(negedge clk);
    core_ok = 1'b1;
    repeat (20) @(negedge clk);
    check("R8 glitch ready", ready, 1);
    check("R8 glitch abort flag", bo_seen, 0);

    // R7/R9/R10: I/O brownout
    io_ok = 1'b0;
    edges_until(1'b0, 100, n);
    check("R7 fall latency io", n, FALL_LAT);
    check("R9 abort on entry", abort_p, 1);
    check("R5 ce forced", mem_ce_n, 1);
    check("R5 we forced", mem_we_n, 1);
    @(posedge clk); #1;
    check("R9 abort one cycle", abort_p, 0);
    check("R10 seen set", bo_seen, 1);

    // R11: recovery needs start flag
    @(negedge clk); io_ok = 1'b1;
    hold_not_ready("R11 no start after inhibit", 40);
    check("R10 seen held", bo_seen, 1);
    clr_bo = 1'b1;
    @(negedge clk); clr_bo = 1'b0;
    check("R10 seen cleared", bo_seen, 0);
    core_start = 1'b1;
    edges_until(1'b1, 200, n);
    check("R11 full delay again", n, RISE_LAT);

    // R7: core brownout, then full recovery
    @(negedge clk); core_ok = 1'b0; core_start = 1'b0;
    edges_until(1'b0, 100, n);
    check("R7 fall latency core", n, FALL_LAT);
    repeat (10) @(negedge clk);
    core_ok = 1'b1; core_start = 1'b1;
    edges_until(1'b1, 200, n);
    check("R11 recovery latency", n, RISE_LAT);

    // R12: start flag lost during the count
    @(negedge clk); io_ok = 1'b0;
    edges_until(1'b0, 100, n);
    check("R7 fall latency repeat", n, FALL_LAT);
    @(negedge clk); io_ok = 1'b1;
    hold_not_ready("R12 counting", RISE_LAT - 12);
    core_start = 1'b0;
    hold_not_ready("R12 start lost", 10);
    core_start = 1'b1;
    edges_until(1'b1, 200, n);
    check("R12 restarted count", n, RISE_LAT);

    // R1: asynchronous reset while ready
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 async ready", ready, 0);
    check("R1 async ce", mem_ce_n, 1);
    check("R1 async we", mem_we_n, 1);

    finish_run();
  end
endmodule